// File: doc/BRIEF.md
# Multicycle RISC Instruction Sequencer

A 32-bit processor core that runs a small RISC instruction set. Each instruction is carried out as a chain of single-clock steps. A finite-state controller moves through those steps, and the number of steps depends on the instruction class. Every step reuses one shared ALU and one shared memory port. The core holds the following state:

- a program counter
- an instruction register
- two operand latches
- an ALU result latch
- a memory data latch
- a 32-entry register file

The core connects to a single unified instruction/data memory. That memory sees one address, one read-data bus, one write-data bus and a write strobe. The word addressed during a step must be presented on the read-data bus within that same step, so that the core can capture it at the end of the step.

Instruction encoding:

- The opcode sits in bits 31..26. The first source register index is in bits 25..21, the second source/target index in bits 20..16, and the R-type destination in bits 15..11.
- The 16-bit immediate (bits 15..0) is sign-extended wherever it is used.
- Opcodes: 0x00 R-type, 0x23 load word, 0x2B store word, 0x04 branch-if-equal, 0x02 jump.

Top module: `seqcpu_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and puts the controller in the fetch step. While reset is held, `mem_addr` is 0 and `mem_we` is 0.
- R2: In the fetch step, `mem_addr` equals the program counter and the returned word is latched as the instruction. From the next step on, `mem_addr` shows the program counter plus 4.
- R3: Register 0 always reads as zero, and a write to it is discarded. A store of register 0 drives 0 on `mem_wdata`.
- R4: An R-type instruction takes 4 cycles and writes its result to register bits 15..11 in the fourth step. The function field (bits 5..0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. Any other function code produces 0.
- R5: A load takes 5 cycles. In step 4, `mem_addr` is the first source register plus the sign-extended immediate. In step 5 the loaded word is written to register bits 20..16.
- R6: A store takes 4 cycles. In step 4, `mem_we` is 1, `mem_addr` is the first source register plus the sign-extended immediate, and `mem_wdata` is register bits 20..16. `mem_we` is 0 in every other step.
- R7: A branch-if-equal takes 3 cycles. If both source registers are equal, the next fetch address is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it is PC+4.
- R8: A jump takes 3 cycles. The next fetch address is bits 31..28 of PC+4, followed by bits 25..0 of the instruction, followed by two zero bits.
- R9: An unrecognised opcode takes 2 cycles (fetch and decode) and changes no state except the program counter advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address for the current memory step |
| mem_rdata | input | 32 | Word read at `mem_addr`, valid within the same step |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe for the store step |

## Verification
The bench runs one program that mixes all five ALU functions, an unknown function code, loads, stores with positive and negative offsets, a taken branch and a not-taken branch, a jump, an unknown opcode and a write to register 0.

A behavioural reference model predicts the memory port for every cycle:

- The address trace shows the step count of each class and the control-flow targets, so a wrong target or a wrong step count shows up as a divergence.
- The store data exposes register-file contents. This separates the ALU operations, the signed compare and the register-0 rule.

After the run, the data memory is compared word by word against the model's copy.

// File: rtl/seqcpu_pkg.sv
package seqcpu_pkg;
   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] OPC_BEQ   = 6'h04;
   localparam logic [5:0] OPC_JUMP  = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [3:0] {
      ST_FETCH, ST_DECODE, ST_EXE_R, ST_EXE_M, ST_EXE_BR, ST_EXE_J,
      ST_WB_R, ST_MEM_RD, ST_MEM_WR, ST_WB_LD
   } step_t;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_ZERO
   } alu_op_t;

   function automatic alu_op_t funct_to_op(input logic [5:0] fn);
      case (fn)
         FN_ADD:  return ALU_ADD;
         FN_SUB:  return ALU_SUB;
         FN_AND:  return ALU_AND;
         FN_OR:   return ALU_OR;
         FN_SLT:  return ALU_SLT;
         default: return ALU_ZERO;
      endcase
   endfunction
endpackage

// File: rtl/seqcpu_alu.sv
module seqcpu_alu
   import seqcpu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_t      op,
   output logic [W-1:0] y,
   output logic         zero
);
   initial assert (W >= 2) else $error("ALU width too small");

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/seqcpu_regfile.sv
module seqcpu_regfile #(
   parameter int W     = 32,
   parameter int N     = 32,
   parameter int PORTS = 2,
   localparam int IW   = $clog2(N)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [PORTS-1:0][IW-1:0] raddr,
   output logic [PORTS-1:0][W-1:0]  rdata,
   input  logic                    we,
   input  logic [IW-1:0]           waddr,
   input  logic [W-1:0]            wdata
);
   initial assert (N == (1 << IW)) else $error("register count must be a power of two");

   logic [W-1:0] regs [N];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) regs[i] <= '0;
      end else if (we && (waddr != '0)) begin
         regs[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_rd
      assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
   end
endmodule

// File: rtl/seqcpu_ctrl.sv
module seqcpu_ctrl
   import seqcpu_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [5:0] opcode,
   output step_t      step
);
   step_t nxt;

   always_comb begin
      nxt = ST_FETCH;
      case (step)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            case (opcode)
               OPC_RTYPE:           nxt = ST_EXE_R;
               OPC_LOAD, OPC_STORE: nxt = ST_EXE_M;
               OPC_BEQ:             nxt = ST_EXE_BR;
               OPC_JUMP:            nxt = ST_EXE_J;
               default:             nxt = ST_FETCH;
            endcase
         end
         ST_EXE_R:  nxt = ST_WB_R;
         ST_EXE_M:  nxt = (opcode == OPC_LOAD) ? ST_MEM_RD : ST_MEM_WR;
         ST_MEM_RD: nxt = ST_WB_LD;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) step <= ST_FETCH;
      else     step <= nxt;
   end

   // R4
   rtype_len_chk: assert property (@(posedge clk) disable iff (rst)
      step == ST_WB_R |=> step == ST_FETCH);
endmodule

// File: rtl/seqcpu_core.sv
module seqcpu_core
   import seqcpu_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          NREG     = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] mem_addr,
   input  logic [XLEN-1:0] mem_rdata,
   output logic [XLEN-1:0] mem_wdata,
   output logic            mem_we
);
   localparam int RIDX = $clog2(NREG);
   localparam int IMMW = 16;

   initial assert (XLEN == 32) else $error("encoding needs a 32-bit word");
   initial assert (NREG == 32) else $error("register fields are 5 bits wide");

   step_t step;
   logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, alu_q, mdr_q;
   logic [XLEN-1:0] imm_sx, alu_a, alu_b, alu_y;
   logic            alu_zero;
   alu_op_t         alu_op;

   logic [1:0][RIDX-1:0] rf_ra;
   logic [1:0][XLEN-1:0] rf_rd;
   logic                 rf_we;
   logic [RIDX-1:0]      rf_wa;
   logic [XLEN-1:0]      rf_wd;

   assign imm_sx = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};

   seqcpu_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .opcode (ir_q[31:26]),
      .step   (step)
   );

   always_comb begin
      alu_a  = pc_q;
      alu_b  = 32'd4;
      alu_op = ALU_ADD;
      case (step)
         ST_DECODE: alu_b = {imm_sx[XLEN-3:0], 2'b00};
         ST_EXE_R: begin
            alu_a  = a_q;
            alu_b  = b_q;
            alu_op = funct_to_op(ir_q[5:0]);
         end
         ST_EXE_M: begin
            alu_a = a_q;
            alu_b = imm_sx;
         end
         ST_EXE_BR: begin
            alu_a  = a_q;
            alu_b  = b_q;
            alu_op = ALU_SUB;
         end
         default: ;
      endcase
   end

   seqcpu_alu #(.W(XLEN)) u_alu (
      .a    (alu_a),
      .b    (alu_b),
      .op   (alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign rf_ra[0] = ir_q[21 +: RIDX];
   assign rf_ra[1] = ir_q[16 +: RIDX];
   assign rf_we    = (step == ST_WB_R) || (step == ST_WB_LD);
   assign rf_wa    = (step == ST_WB_R) ? ir_q[11 +: RIDX] : ir_q[16 +: RIDX];
   assign rf_wd    = (step == ST_WB_R) ? alu_q : mdr_q;

   seqcpu_regfile #(.W(XLEN), .N(NREG), .PORTS(2)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .raddr (rf_ra),
      .rdata (rf_rd),
      .we    (rf_we),
      .waddr (rf_wa),
      .wdata (rf_wd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= RESET_PC;
         ir_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         alu_q <= '0;
         mdr_q <= '0;
      end else begin
         case (step)
            ST_FETCH: begin
               ir_q <= mem_rdata;
               pc_q <= alu_y;
            end
            ST_DECODE: begin
               a_q   <= rf_rd[0];
               b_q   <= rf_rd[1];
               alu_q <= alu_y;
            end
            ST_EXE_R, ST_EXE_M: alu_q <= alu_y;
            ST_EXE_BR: if (alu_zero) pc_q <= alu_q;
            ST_EXE_J:  pc_q <= {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
            ST_MEM_RD: mdr_q <= mem_rdata;
            default: ;
         endcase
      end
   end

   assign mem_addr  = (step == ST_MEM_RD || step == ST_MEM_WR) ? alu_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_we    = (step == ST_MEM_WR);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (pc_q == RESET_PC) && (step == ST_FETCH));

   // R2
   pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
      step == ST_FETCH |=> pc_q == $past(pc_q) + 32'd4);

   // R3
   zero_src_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_DECODE) && (ir_q[25:21] == 5'd0) |=> a_q == '0);

   // R5
   load_capture_chk: assert property (@(posedge clk) disable iff (rst)
      step == ST_MEM_RD |=> mdr_q == $past(mem_rdata));

   // R6
   store_ends_chk: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> step == ST_FETCH);

   // R7
   branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (step == ST_EXE_BR) && (a_q == b_q) |=> pc_q == $past(alu_q));
endmodule

// File: tb/seqcpu_core_test.sv
module seqcpu_core_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] mem_addr, mem_rdata, mem_wdata;
   logic        mem_we;

   int compared = 0;
   int mismatched = 0;

   always #4 clk = ~clk;

   logic [31:0] phys [256];
   assign mem_rdata = phys[mem_addr[9:2]];
   always @(posedge clk) if (mem_we) phys[mem_addr[9:2]] <= mem_wdata;

   seqcpu_core uut (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we)
   );

   // reference model state
   logic [31:0] rmem [256];
   logic [31:0] rr [32];
   string       rtag [32];
   logic [31:0] rpc;
   string       ftag;
   logic [31:0] q_addr [$];
   bit          q_we [$];
   logic [31:0] q_wd [$];
   string       q_tag [$];

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, rs[4:0], rt[4:0], imm};
   endfunction

   task automatic push(logic [31:0] a, bit w, logic [31:0] d, string t);
      q_addr.push_back(a); q_we.push_back(w); q_wd.push_back(d); q_tag.push_back(t);
   endtask

   task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", t, act, exp);
      end
   endtask

   task automatic model_step();
      logic [31:0] ins, npc, ea, res, sx, va, vb;
      int rs, rt, rd;
      ins = rmem[rpc[9:2]];
      push(rpc, 0, 0, ftag);
      npc = rpc + 4;
      push(npc, 0, 0, "R2");
      ftag = "R2";
      rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
      va = rr[rs]; vb = rr[rt];
      sx = {{16{ins[15]}}, ins[15:0]};
      ea = va + sx;
      rpc = npc;
      case (ins[31:26])
         6'h00: begin
            case (ins[5:0])
               6'h20: res = va + vb;
               6'h22: res = va - vb;
               6'h24: res = va & vb;
               6'h25: res = va | vb;
               6'h2A: res = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
               default: res = 0;
            endcase
            push(npc, 0, 0, "R4"); push(npc, 0, 0, "R4");
            if (rd != 0) begin rr[rd] = res; rtag[rd] = "R4"; end
         end
         6'h23: begin
            push(npc, 0, 0, "R5"); push(ea, 0, 0, "R5"); push(npc, 0, 0, "R5");
            if (rt != 0) begin rr[rt] = rmem[ea[9:2]]; rtag[rt] = "R5"; end
         end
         6'h2B: begin
            push(npc, 0, 0, "R6"); push(ea, 1, vb, {"R6/", rtag[rt]});
            rmem[ea[9:2]] = vb;
         end
         6'h04: begin
            push(npc, 0, 0, "R7");
            if (va == vb) rpc = npc + {sx[29:0], 2'b00};
            ftag = "R7";
         end
         6'h02: begin
            push(npc, 0, 0, "R8");
            rpc = {npc[31:28], ins[25:0], 2'b00};
            ftag = "R8";
         end
         default: ftag = "R9";
      endcase
   endtask

   initial begin
      #(8 * 5000);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) phys[i] = 32'h0;
      phys[0]  = enc_i(6'h23, 0, 1, 16'h0100);
      phys[1]  = enc_i(6'h23, 0, 2, 16'h0104);
      phys[2]  = enc_i(6'h23, 0, 9, 16'h010C);
      phys[3]  = enc_i(6'h23, 0, 10, 16'h0100);
      phys[4]  = enc_r(1, 2, 3, 6'h20);
      phys[5]  = enc_r(1, 2, 4, 6'h22);
      phys[6]  = enc_r(1, 2, 5, 6'h24);
      phys[7]  = enc_r(1, 2, 6, 6'h25);
      phys[8]  = enc_r(2, 1, 7, 6'h2A);
      phys[9]  = enc_r(1, 2, 8, 6'h2A);
      phys[10] = enc_r(1, 1, 0, 6'h20);
      phys[11] = enc_r(1, 2, 10, 6'h00);
      phys[12] = enc_i(6'h2B, 0, 3, 16'h0110);
      phys[13] = enc_i(6'h2B, 0, 4, 16'h0114);
      phys[14] = enc_i(6'h2B, 0, 5, 16'h0118);
      phys[15] = enc_i(6'h2B, 9, 6, 16'hFFFC);
      phys[16] = enc_i(6'h2B, 0, 7, 16'h0120);
      phys[17] = enc_i(6'h2B, 0, 8, 16'h0124);
      phys[18] = enc_i(6'h2B, 0, 0, 16'h0128);
      phys[19] = enc_i(6'h2B, 0, 10, 16'h012C);
      phys[20] = enc_i(6'h04, 1, 2, 16'h0003);
      phys[21] = enc_i(6'h04, 3, 3, 16'h0002);
      phys[22] = enc_i(6'h2B, 0, 4, 16'h0130);
      phys[23] = enc_i(6'h2B, 0, 4, 16'h0130);
      phys[24] = 32'hFC00_0000;
      phys[25] = {6'h02, 26'd28};
      phys[26] = enc_i(6'h2B, 0, 1, 16'h0134);
      phys[27] = enc_i(6'h2B, 0, 1, 16'h0134);
      phys[28] = enc_i(6'h23, 0, 11, 16'h0108);
      phys[29] = enc_i(6'h2B, 0, 11, 16'h0134);
      phys[30] = enc_i(6'h04, 0, 0, 16'hFFFF);
      phys[64] = 32'h0000_0007;
      phys[65] = 32'hFFFF_FFFD;
      phys[66] = 32'h1234_5678;
      phys[67] = 32'h0000_0120;
      for (int i = 0; i < 256; i++) rmem[i] = phys[i];
      for (int i = 0; i < 32; i++) begin rr[i] = 0; rtag[i] = "R3"; end
      rpc = 0;
      ftag = "R1";

      // R1: outputs during reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 addr", mem_addr, 32'h0);
      chk("R1 we", {31'd0, mem_we}, 32'h0);
      rst = 1'b0;

      for (int cyc = 0; cyc < 220; cyc++) begin
         if (cyc != 0) @(negedge clk);
         if (q_addr.size() == 0) model_step();
         begin
            logic [31:0] ea, ed;
            bit ew;
            string et;
            ea = q_addr.pop_front(); ew = q_we.pop_front();
            ed = q_wd.pop_front(); et = q_tag.pop_front();
            chk({et, " addr"}, mem_addr, ea);
            chk({et, " we R6"}, {31'd0, mem_we}, {31'd0, ew});
            if (ew) chk({et, " wdata"}, mem_wdata, ed);
         end
      end

      // R6: data memory contents after the run
      @(negedge clk);
      for (int i = 64; i < 80; i++) chk("R6 mem", phys[i], rmem[i]);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule